// File: doc/BRIEF.md
# Floating-Point to 32-Bit Integer Converter

This block turns one IEEE-754 operand, binary64 or binary32, into a 32-bit integer. The integer is signed or unsigned, as the caller picks. There are three rounding behaviours: nearest with ties to even, toward minus infinity, and toward zero. A per-operation control can force round-toward-zero whatever mode is programmed. Any operand the integer range cannot hold raises an invalid flag and returns a saturated value. A NaN operand returns zero. A valid conversion that drops a nonzero fraction raises an inexact flag.

Operands arrive on a valid/ready input handshake. Results leave on a valid/ready output handshake one cycle after acceptance. A single output register sits between the two sides. It accepts a new operand in the same cycle that the held result is consumed, so back-to-back traffic runs at full rate.

Top module: `fp2int_cvt`

## Requirements
- R1: With `in_double`=1 the operand is binary64 in all 64 bits (sign bit 63, exponent 62:52, fraction 51:0). With `in_double`=0 it is binary32 in bits 31:0 (sign 31, exponent 30:23, fraction 22:0), and bits 63:32 have no effect.
- R2: With `in_signed`=1 the result is a two's-complement signed 32-bit integer. With `in_signed`=0 it is an unsigned 32-bit integer.
- R3: The `in_rmode` field selects rounding: 00 is nearest-even, 10 is toward minus infinity, 11 is toward zero, and 01 acts as toward zero. With `in_force_rz`=1 the block rounds toward zero whatever `in_rmode` holds.
- R4: A NaN operand gives `out_invalid`=1, `out_result`=0 and `out_inexact`=0.
- R5: The invalid flag depends on the mode. Nearest, signed: v >= 2147483647.5 or v < -2147483648.5. Nearest, unsigned: v >= 4294967295.5 or v < -0.5. Toward minus infinity: v >= 2^31 or v < -2^31 signed, v >= 2^32 or v < 0 unsigned. Toward zero: v >= 2^31 or v <= -2^31-1 signed, v >= 2^32 or v <= -1 unsigned. Infinities are out of range.
- R6: An invalid non-NaN operand saturates. A negative operand gives 0x80000000 signed or 0x00000000 unsigned. A positive operand gives 0x7FFFFFFF signed or 0xFFFFFFFF unsigned.
- R7: In nearest mode an exact half resolves to the even integer. A fraction above one half moves the magnitude one step away from zero, and a fraction below one half is dropped.
- R8: In minus-infinity mode a non-integer operand goes to the next lower integer. A negative subnormal gives -1 (0xFFFFFFFF) when signed and is invalid when unsigned.
- R9: `out_inexact` is 1 exactly when the operand is valid and has a nonzero fractional part.
- R10: `in_ready` is 1 when no result is held or the held result is taken in that cycle. An operand accepted at a clock edge shows on the outputs, with `out_valid`=1, straight after that edge. A held result stays unchanged while `out_ready`=0.
- R11: Zeros and subnormals convert to 0. A nonzero subnormal is inexact, except in the case R8 gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand present |
| in_ready | output | 1 | Operand can be accepted |
| in_operand | input | 64 | Floating-point operand bits |
| in_double | input | 1 | 1 = binary64, 0 = binary32 in low half |
| in_signed | input | 1 | 1 = signed result, 0 = unsigned |
| in_force_rz | input | 1 | 1 = round toward zero regardless of mode |
| in_rmode | input | 2 | Rounding mode select |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Converted integer |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The block keeps no state from one operand to the next apart from the output register. A wrong alignment shift, a wrong round increment or a wrong range limit shows up as a bad `out_result` or flag in the cycle right after the operand is accepted. The corner vectors sit on the range limits of each mode, on exact half-way values and on subnormals, because an off-by-one in a limit or a tie rule changes the output only there. A fault in the handshake register shows at the ports within a cycle or two of a stall, as a result that changes or is lost while `out_ready` is low.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;
  localparam int RES_W   = 32;
  localparam int D_EXP_W = 11;
  localparam int D_MAN_W = 52;
  localparam int S_EXP_W = 8;
  localparam int S_MAN_W = 23;
  localparam int D_BIAS  = (1 << (D_EXP_W - 1)) - 1;
  localparam int S_BIAS  = (1 << (S_EXP_W - 1)) - 1;
  localparam int EXP_W   = D_EXP_W + 2;
  localparam int EXT_W   = D_MAN_W + 1 + RES_W + 1;
  localparam int MAG_W   = EXT_W - D_MAN_W;
  localparam int SH_W    = $clog2(RES_W + 1);
  localparam int OP_W    = 1 + D_EXP_W + D_MAN_W;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_ALT_RZ  = 2'b01,
    RND_FLOOR   = 2'b10,
    RND_TRUNC   = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic                    sign;
    logic                    nan;
    logic                    inf;
    logic                    tiny;
    logic                    frac_nz;
    logic signed [EXP_W-1:0] exp;
    logic [D_MAN_W:0]        mant;
  } fp_fields_t;
endpackage

// File: rtl/fp2int_unpack.sv
module fp2int_unpack
  import fp2int_pkg::*;
(
  input  logic [OP_W-1:0] op_bits,
  input  logic            is_double,
  output fp_fields_t      fld
);
  logic [D_EXP_W-1:0] d_exp;
  logic [D_MAN_W-1:0] d_frac;
  logic [S_EXP_W-1:0] s_exp;
  logic [S_MAN_W-1:0] s_frac;

  assign d_exp  = op_bits[OP_W-2 -: D_EXP_W];
  assign d_frac = op_bits[D_MAN_W-1:0];
  assign s_exp  = op_bits[RES_W-2 -: S_EXP_W];
  assign s_frac = op_bits[S_MAN_W-1:0];

  always_comb begin
    fld = '0;
    if (is_double) begin
      fld.sign    = op_bits[OP_W-1];
      fld.tiny    = (d_exp == '0);
      fld.frac_nz = (d_frac != '0);
      fld.nan     = (d_exp == '1) && (d_frac != '0);
      fld.inf     = (d_exp == '1) && (d_frac == '0);
      fld.exp     = $signed({2'b00, d_exp}) - $signed(EXP_W'(D_BIAS));
      fld.mant    = {1'b1, d_frac};
    end else begin
      fld.sign    = op_bits[RES_W-1];
      fld.tiny    = (s_exp == '0);
      fld.frac_nz = (s_frac != '0);
      fld.nan     = (s_exp == '1) && (s_frac != '0);
      fld.inf     = (s_exp == '1) && (s_frac == '0);
      fld.exp     = $signed({{(EXP_W-S_EXP_W){1'b0}}, s_exp}) - $signed(EXP_W'(S_BIAS));
      fld.mant    = {1'b1, s_frac, {(D_MAN_W-S_MAN_W){1'b0}}};
    end
  end
endmodule

// File: rtl/fp2int_core.sv
module fp2int_core
  import fp2int_pkg::*;
(
  input  fp_fields_t       fld,
  input  rnd_mode_e        mode,
  input  logic             is_signed,
  output logic [RES_W-1:0] res,
  output logic             inv,
  output logic             inx
);
  localparam logic signed [EXP_W-1:0] EXP_TOP   = EXP_W'(RES_W);
  localparam logic signed [EXP_W-1:0] EXP_HALF  = -1;
  localparam logic [MAG_W-1:0]        LIM_SNEG  = MAG_W'(1) << (RES_W - 1);
  localparam logic [MAG_W-1:0]        LIM_SPOS  = LIM_SNEG - MAG_W'(1);
  localparam logic [MAG_W-1:0]        LIM_UPOS  = (MAG_W'(1) << RES_W) - MAG_W'(1);
  localparam logic [RES_W-1:0]        SAT_SMIN  = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0]        SAT_SMAX  = ~SAT_SMIN;

  logic [EXT_W-1:0] ext;
  logic [MAG_W-1:0] int_mag, rnd_mag, lim;
  logic             half, sticky, huge, inc, oor;
  logic [RES_W-1:0] sat;

  // Alignment: integer magnitude plus round and sticky bits
  always_comb begin
    ext     = '0;
    int_mag = '0;
    half    = 1'b0;
    sticky  = 1'b0;
    huge    = 1'b0;
    if (fld.tiny) begin
      sticky = fld.frac_nz;
    end else if (fld.exp > EXP_TOP) begin
      huge = 1'b1;
    end else if (fld.exp >= 0) begin
      ext     = {{(RES_W+1){1'b0}}, fld.mant} << fld.exp[SH_W-1:0];
      int_mag = ext[EXT_W-1:D_MAN_W];
      half    = ext[D_MAN_W-1];
      sticky  = |ext[D_MAN_W-2:0];
    end else if (fld.exp == EXP_HALF) begin
      half   = 1'b1;
      sticky = |fld.mant[D_MAN_W-1:0];
    end else begin
      sticky = 1'b1;
    end
  end

  // Rounding increment on the magnitude
  always_comb begin
    unique case (mode)
      RND_NEAREST: inc = half & (sticky | int_mag[0]);
      RND_FLOOR:   inc = fld.sign & (half | sticky);
      default:     inc = 1'b0;
    endcase
  end

  assign rnd_mag = int_mag + MAG_W'(inc);

  // Range check after rounding, then saturation or negation
  always_comb begin
    if (is_signed) lim = fld.sign ? LIM_SNEG : LIM_SPOS;
    else           lim = fld.sign ? '0       : LIM_UPOS;
    oor = (rnd_mag > lim);
    inv = fld.nan | fld.inf | huge | oor;
    if (fld.nan)        sat = '0;
    else if (is_signed) sat = fld.sign ? SAT_SMIN : SAT_SMAX;
    else                sat = fld.sign ? '0 : '1;
    if (inv)           res = sat;
    else if (fld.sign) res = -rnd_mag[RES_W-1:0];
    else               res = rnd_mag[RES_W-1:0];
    inx = ~inv & (half | sticky);
  end
endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
  import fp2int_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_operand,
  input  logic             in_double,
  input  logic             in_signed,
  input  logic             in_force_rz,
  input  logic [1:0]       in_rmode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] out_result,
  output logic             out_invalid,
  output logic             out_inexact
);
  fp_fields_t       fld;
  rnd_mode_e        eff_mode;
  logic [RES_W-1:0] core_res;
  logic             core_inv, core_inx;
  logic             accept, vld_d, vld_q;
  logic [RES_W-1:0] res_q;
  logic             inv_q, inx_q;

  assign eff_mode = in_force_rz ? RND_TRUNC : rnd_mode_e'(in_rmode);

  fp2int_unpack u_unpack (
    .op_bits   (in_operand),
    .is_double (in_double),
    .fld       (fld)
  );

  fp2int_core u_core (
    .fld       (fld),
    .mode      (eff_mode),
    .is_signed (in_signed),
    .res       (core_res),
    .inv       (core_inv),
    .inx       (core_inx)
  );

  // Next state
  always_comb begin
    in_ready = ~vld_q | out_ready;
    accept   = in_valid & in_ready;
    vld_d    = accept | (vld_q & ~out_ready);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
      inx_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (accept) begin
        res_q <= core_res;
        inv_q <= core_inv;
        inx_q <= core_inx;
      end
    end
  end

  assign out_valid   = vld_q;
  assign out_result  = res_q;
  assign out_invalid = inv_q;
  assign out_inexact = inx_q;

  a_r4_nan_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && fld.nan) |-> (core_inv && core_res == '0 && !core_inx));

  a_r6_sat_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && core_inv) |->
      (core_res == '0 || core_res == '1 ||
       core_res == {1'b1, {(RES_W-1){1'b0}}} || core_res == {1'b0, {(RES_W-1){1'b1}}}));

  a_r9_inexact_excl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));

  a_r2_signed_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed && !core_inv && fld.sign && core_res != '0) |-> core_res[RES_W-1]);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_invalid) && $stable(out_inexact)));
endmodule

// File: tb/fp2int_cvt_tb_top.sv
module fp2int_cvt_tb_top;
  localparam logic [1:0] RN = 2'b00, RX = 2'b01, RM = 2'b10, RZ = 2'b11;

  logic        clk, rst_n;
  logic        in_valid, in_ready, in_double, in_signed, in_force_rz;
  logic [63:0] in_operand;
  logic [1:0]  in_rmode;
  logic        out_valid, out_ready, out_invalid, out_inexact;
  logic [31:0] out_result;
  int          n_vec, n_bad;

  fp2int_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_double(in_double), .in_signed(in_signed),
    .in_force_rz(in_force_rz), .in_rmode(in_rmode), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_invalid(out_invalid),
    .out_inexact(out_inexact)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] dbl(input real r);
    return $realtobits(r);
  endfunction

  function automatic logic [63:0] flt(input real r);
    logic [63:0] b;
    logic [10:0] e;
    b = $realtobits(r);
    e = b[62:52] - 11'd1023 + 11'd127;
    return {32'hA5A5_5A5A, b[63], e[7:0], b[51:29]};
  endfunction

  task automatic check(input string tag, input logic [31:0] gr, input logic gi, input logic gx,
                       input logic [31:0] er, input logic ei, input logic ex);
    n_vec++;
    if (gr !== er || gi !== ei || gx !== ex) begin
      n_bad++;
      $display("FAIL %s: got res=%h inv=%b inx=%b, expected res=%h inv=%b inx=%b",
               tag, gr, gi, gx, er, ei, ex);
    end
  endtask

  task automatic run(input string tag, input logic [63:0] op, input logic dp, input logic sg,
                     input logic fz, input logic [1:0] md,
                     input logic [31:0] er, input logic ei, input logic ex);
    @(negedge clk);
    in_operand = op; in_double = dp; in_signed = sg; in_force_rz = fz; in_rmode = md;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (out_valid !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 %s: out_valid=%b expected 1", tag, out_valid);
    end
    check(tag, out_result, out_invalid, out_inexact, er, ei, ex);
  endtask

  task automatic t_reset;
    n_vec++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R10 reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
  endtask

  task automatic t_precision; // R1
    run("R1 dbl 3.0",  dbl(3.0),  1, 1, 0, RZ, 32'd3, 0, 0);
    run("R1 flt 3.0",  flt(3.0),  0, 1, 0, RZ, 32'd3, 0, 0);
    run("R1 flt -2.5", flt(-2.5), 0, 1, 0, RN, 32'hFFFF_FFFE, 0, 1);
    run("R1 flt 1e9",  flt(1000000000.0), 0, 0, 0, RN, 32'd1000000000, 0, 0);
  endtask

  task automatic t_nearest; // R7
    run("R7 2.5",  dbl(2.5),  1, 1, 0, RN, 32'd2, 0, 1);
    run("R7 3.5",  dbl(3.5),  1, 1, 0, RN, 32'd4, 0, 1);
    run("R7 -2.5", dbl(-2.5), 1, 1, 0, RN, 32'hFFFF_FFFE, 0, 1);
    run("R7 2.6",  dbl(2.6),  1, 1, 0, RN, 32'd3, 0, 1);
    run("R7 2.4",  dbl(2.4),  1, 1, 0, RN, 32'd2, 0, 1);
    run("R7 0.5",  dbl(0.5),  1, 0, 0, RN, 32'd0, 0, 1);
  endtask

  task automatic t_floor; // R8
    run("R8 -1.5", dbl(-1.5), 1, 1, 0, RM, 32'hFFFF_FFFE, 0, 1);
    run("R8 1.7",  dbl(1.7),  1, 1, 0, RM, 32'd1, 0, 1);
    run("R8 -3.0", dbl(-3.0), 1, 1, 0, RM, 32'hFFFF_FFFD, 0, 0);
    run("R8 negsub signed",   64'h8000_0000_0000_0001, 1, 1, 0, RM, 32'hFFFF_FFFF, 0, 1);
    run("R8 negsub unsigned", 64'h8000_0000_0000_0001, 1, 0, 0, RM, 32'h0, 1, 0);
  endtask

  task automatic t_modes; // R3, R2
    run("R3 mode01 2.7", dbl(2.7),  1, 1, 0, RX, 32'd2, 0, 1);
    run("R3 force 2.7",  dbl(2.7),  1, 1, 1, RN, 32'd2, 0, 1);
    run("R3 force -1.5", dbl(-1.5), 1, 1, 1, RM, 32'hFFFF_FFFF, 0, 1);
    run("R3 RZ -2.7",    dbl(-2.7), 1, 1, 0, RZ, 32'hFFFF_FFFE, 0, 1);
    run("R2 unsigned 3e9", dbl(3000000000.0), 1, 0, 0, RZ, 32'd3000000000, 0, 0);
    run("R2 signed 3e9",   dbl(3000000000.0), 1, 1, 0, RZ, 32'h7FFF_FFFF, 1, 0);
  endtask

  task automatic t_range; // R5, R6
    run("R5 RN s +tie",   dbl(2147483647.5),  1, 1, 0, RN, 32'h7FFF_FFFF, 1, 0);
    run("R5 RN s +below", dbl(2147483647.25), 1, 1, 0, RN, 32'h7FFF_FFFF, 0, 1);
    run("R5 RN s -tie",   dbl(-2147483648.5), 1, 1, 0, RN, 32'h8000_0000, 0, 1);
    run("R5 RN s -over",  dbl(-2147483648.75),1, 1, 0, RN, 32'h8000_0000, 1, 0);
    run("R5 RN u -0.5",   dbl(-0.5),  1, 0, 0, RN, 32'h0, 0, 1);
    run("R5 RN u -0.75",  dbl(-0.75), 1, 0, 0, RN, 32'h0, 1, 0);
    run("R5 RN u top",    dbl(4294967295.5), 1, 0, 0, RN, 32'hFFFF_FFFF, 1, 0);
    run("R5 RM u below",  dbl(4294967295.5), 1, 0, 0, RM, 32'hFFFF_FFFF, 0, 1);
    run("R5 RM u 2^32",   dbl(4294967296.0), 1, 0, 0, RM, 32'hFFFF_FFFF, 1, 0);
    run("R5 RM s -2^31",  dbl(-2147483648.0), 1, 1, 0, RM, 32'h8000_0000, 0, 0);
    run("R5 RM s under",  dbl(-2147483648.5), 1, 1, 0, RM, 32'h8000_0000, 1, 0);
    run("R5 RZ s -.75",   dbl(-2147483648.75),1, 1, 0, RZ, 32'h8000_0000, 0, 1);
    run("R5 RZ s -2^31-1",dbl(-2147483649.0), 1, 1, 0, RZ, 32'h8000_0000, 1, 0);
    run("R5 RZ u -0.75",  dbl(-0.75), 1, 0, 0, RZ, 32'h0, 0, 1);
    run("R5 RZ u -1",     dbl(-1.0),  1, 0, 0, RZ, 32'h0, 1, 0);
    run("R6 +inf s", 64'h7FF0_0000_0000_0000, 1, 1, 0, RN, 32'h7FFF_FFFF, 1, 0);
    run("R6 -inf s", 64'hFFF0_0000_0000_0000, 1, 1, 0, RZ, 32'h8000_0000, 1, 0);
    run("R6 big u",  dbl(1.0e20), 1, 0, 0, RZ, 32'hFFFF_FFFF, 1, 0);
    run("R6 -big u", dbl(-1.0e20), 1, 0, 0, RN, 32'h0, 1, 0);
  endtask

  task automatic t_nan; // R4
    run("R4 dbl nan", 64'h7FF8_0000_0000_0000, 1, 1, 0, RN, 32'h0, 1, 0);
    run("R4 flt nan", 64'h0000_0000_FFC0_0001, 0, 0, 0, RZ, 32'h0, 1, 0);
  endtask

  task automatic t_tiny; // R11, R9
    run("R11 +0",      64'h0, 1, 1, 0, RN, 32'h0, 0, 0);
    run("R11 -0 u",    64'h8000_0000_0000_0000, 1, 0, 0, RM, 32'h0, 0, 0);
    run("R11 +sub",    64'h0000_0000_0000_0001, 1, 1, 0, RN, 32'h0, 0, 1);
    run("R11 flt sub", 64'h0000_0000_0000_0010, 0, 0, 0, RZ, 32'h0, 0, 1);
    run("R9 exact 5",  dbl(5.0), 1, 0, 0, RN, 32'd5, 0, 0);
  endtask

  task automatic t_stall; // R10
    @(negedge clk);
    out_ready = 1'b0;
    in_operand = dbl(7.0); in_double = 1; in_signed = 1; in_force_rz = 0; in_rmode = RZ;
    in_valid = 1'b1;
    @(negedge clk);
    in_operand = dbl(9.0);
    n_vec++;
    if (in_ready !== 1'b0) begin
      n_bad++; $display("FAIL R10 stall ready: got %b expected 0", in_ready);
    end
    check("R10 first", out_result, out_invalid, out_inexact, 32'd7, 0, 0);
    @(negedge clk);
    check("R10 held", out_result, out_invalid, out_inexact, 32'd7, 0, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next", out_result, out_invalid, out_inexact, 32'd9, 0, 0);
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R10 drain: out_valid=%b expected 0", out_valid);
    end
  endtask

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_operand = '0;
    in_double = 1'b0; in_signed = 1'b0; in_force_rz = 1'b0; in_rmode = RN;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_precision;
    t_nearest;
    t_floor;
    t_modes;
    t_range;
    t_nan;
    t_tiny;
    t_stall;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule